// File: doc/BRIEF.md
# Inbound Isochronous Byte Accumulator with Babble Guard

This block follows the data phase of the inbound isochronous transactions that one endpoint may perform in a single micro-frame. A start strobe arms it with a transaction count (1 to 3), the endpoint's maximum packet size and the allowed transfer length. While it is armed, it counts each received byte into a running total and closes one transaction on every end-of-packet marker. After the programmed number of packets it clears its active flag and gives a one-cycle done pulse. The total then holds the number of bytes received in the micro-frame.

Each packet may carry at most the smaller of the maximum packet size and the allowed length. When a byte arrives beyond that limit, the block raises a sticky babble flag, drops the excess byte, clears active and ends the micro-frame at once with a done pulse. A packet that ends below the limit is a short packet. It finishes normally and gives no error indication of any kind.

Top module: `in_byte_accum`

## Requirements
- R1: A start pulse while inactive with a count of 1, 2 or 3 sets active on the next clock edge and clears the total and the babble flag.
- R2: A start pulse while active, or with a count of 0, is ignored: active, total and babble stay unchanged.
- R3: Each byte strobe seen while active that does not exceed the packet limit adds exactly one to the total. Byte strobes seen while inactive leave the total unchanged.
- R4: The packet limit is the lesser of the maximum packet size and the allowed length. The per-packet byte count restarts at zero after every end-of-packet marker.
- R5: A byte strobe that would make the current packet exceed the limit sets babble and clears active on the same edge. That byte is not added to the total.
- R6: When the end-of-packet marker for the last programmed packet arrives, active clears and done is high for exactly one cycle on that same edge.
- R7: After babble no further transaction runs. Done pulses once, later bytes and markers have no effect, and babble stays set until the next accepted start.
- R8: A micro-frame whose packets all stay within the limit, including short packets and empty packets, ends with babble low and the total equal to the sum of the bytes received.
- R9: A byte strobe and an end-of-packet marker in the same cycle count the byte into the packet being closed. If that byte is an excess byte, babble takes precedence and the marker is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm strobe for one micro-frame |
| txn_count | input | 2 | Number of IN transactions (1 to 3) |
| max_pkt | input | 11 | Maximum packet size in bytes |
| allow_len | input | 12 | Allowed length in bytes |
| byte_vld | input | 1 | One received byte this cycle |
| pkt_end | input | 1 | End of the current packet |
| total | output | 12 | Bytes accumulated in the micro-frame |
| babble | output | 1 | Sticky babble-detected status |
| active | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The byte counter and the transaction closer can act in the same cycle, when a byte strobe and the end-of-packet marker arrive together. The sweep drives the final byte of some packets together with the marker and the final byte of other packets on its own. It covers every packet size up to one past the limit, so the excess byte also falls on the marker cycle. These cases are judged by the final total, by whether babble is set, and by whether the packet count advanced, which the bench sees as active staying high or clearing.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int MPS_W  = 11;
  localparam int TOT_W  = 12;
  localparam int MULT_W = 2;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_RUN = 1'b1} seq_state_t;

  // lesser of packet size and allowed length, in packet-size width
  function automatic logic [MPS_W-1:0] pkt_limit(input logic [MPS_W-1:0] mps,
                                                 input logic [TOT_W-1:0] alw);
    if ({{(TOT_W-MPS_W){1'b0}}, mps} <= alw) return mps;
    else return alw[MPS_W-1:0];
  endfunction
endpackage

// File: rtl/limit_latch.sv
module limit_latch
  import accum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic [TOT_W-1:0] allow_len,
  output logic [MPS_W-1:0] limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    limit <= '0;
    else if (load) limit <= pkt_limit(max_pkt, allow_len);
  end
endmodule

// File: rtl/pkt_byte_ctr.sv
module pkt_byte_ctr
  import accum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [MPS_W-1:0] limit,
  input  logic             byte_in,
  input  logic             pkt_close,
  output logic             byte_ok,
  output logic             over
);
  logic [MPS_W-1:0] cnt;

  assign over    = byte_in && (cnt == limit);
  assign byte_ok = byte_in && !over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clear || pkt_close) cnt <= '0;
    else if (byte_ok)            cnt <= cnt + 1'b1;
  end

  AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> cnt <= limit); // R4
  AST_CLOSE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_close |=> cnt == '0); // R4
endmodule

// File: rtl/txn_seq.sv
module txn_seq
  import accum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [MULT_W-1:0] txn_count,
  input  logic              pkt_close,
  input  logic              over,
  output logic              active,
  output logic              babble,
  output logic              done
);
  seq_state_t        st;
  logic [MULT_W-1:0] txn_cnt, txn_max;
  logic              last_close, finish;

  assign last_close = pkt_close && !over && (MULT_W'(txn_cnt + 1'b1) == txn_max);
  assign finish     = (st == SQ_RUN) && (over || last_close);
  assign active     = (st == SQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; txn_cnt <= '0; txn_max <= '0; babble <= 1'b0; done <= 1'b0;
    end else begin
      done <= finish;
      if (start_ok) begin
        st <= SQ_RUN; txn_cnt <= '0; txn_max <= txn_count; babble <= 1'b0;
      end else if (st == SQ_RUN) begin
        if (over) babble <= 1'b1;
        if (finish) st <= SQ_IDLE;
        else if (pkt_close) txn_cnt <= txn_cnt + 1'b1;
      end
    end
  end

  AST_BABBLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> babble && !active && done); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> done); // R7
  AST_TXN_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> txn_cnt < txn_max); // R6
  AST_BABBLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    babble && !start_ok |=> babble); // R7
endmodule

// File: rtl/in_byte_accum.sv
module in_byte_accum
  import accum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MULT_W-1:0] txn_count,
  input  logic [MPS_W-1:0]  max_pkt,
  input  logic [TOT_W-1:0]  allow_len,
  input  logic              byte_vld,
  input  logic              pkt_end,
  output logic [TOT_W-1:0]  total,
  output logic              babble,
  output logic              active,
  output logic              done
);
  logic             start_ok, byte_in, pkt_close, byte_ok, over;
  logic [MPS_W-1:0] limit;

  assign start_ok  = start && !active && (txn_count != '0);
  assign byte_in   = byte_vld && active;
  assign pkt_close = pkt_end && active;

  limit_latch u_lim (.clk(clk), .rst_n(rst_n), .load(start_ok),
                     .max_pkt(max_pkt), .allow_len(allow_len), .limit(limit));

  pkt_byte_ctr u_ctr (.clk(clk), .rst_n(rst_n), .clear(start_ok), .limit(limit),
                      .byte_in(byte_in), .pkt_close(pkt_close),
                      .byte_ok(byte_ok), .over(over));

  txn_seq u_seq (.clk(clk), .rst_n(rst_n), .start_ok(start_ok), .txn_count(txn_count),
                 .pkt_close(pkt_close), .over(over), .active(active),
                 .babble(babble), .done(done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        total <= '0;
    else if (start_ok) total <= '0;
    else if (byte_ok)  total <= total + 1'b1;
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> active && total == '0 && !babble); // R1
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && active && !byte_vld && !pkt_end |=> active && $stable(total)); // R2
  AST_IDLE_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !start_ok |=> $stable(total)); // R3
  AST_EXCESS_NOT_ADDED: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> $stable(total)); // R5
endmodule

// File: tb/tb_in_byte_accum.sv
module tb_in_byte_accum;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, byte_vld = 0, pkt_end = 0;
  logic [1:0]  txn_count = 0;
  logic [10:0] max_pkt = 0;
  logic [11:0] allow_len = 0;
  logic [11:0] total;
  logic        babble, active, done;

  int checks = 0, fails = 0, done_seen = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  in_byte_accum dut (.clk(clk), .rst_n(rst_n), .start(start), .txn_count(txn_count),
                     .max_pkt(max_pkt), .allow_len(allow_len), .byte_vld(byte_vld),
                     .pkt_end(pkt_end), .total(total), .babble(babble),
                     .active(active), .done(done));

  always @(negedge clk) if (done) done_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input bit b, input bit e);
    start = s; byte_vld = b; pkt_end = e;
    @(negedge clk);
    start = 0; byte_vld = 0; pkt_end = 0;
  endtask

  // one micro-frame: packet p carries sz[p] bytes, last byte with marker if comb
  task automatic frame(input int m, input int mps, input int alw, input int sz[3], input bit comb);
    int lim, exp_tot, snt;
    bit exp_bab, stop;
    lim = (mps < alw) ? mps : alw;
    exp_tot = 0; exp_bab = 0; stop = 0;
    for (int p = 0; p < m && !stop; p++) begin
      if (sz[p] > lim) begin exp_tot += lim; exp_bab = 1; stop = 1; end
      else exp_tot += sz[p];
    end
    txn_count = 2'(m); max_pkt = 11'(mps); allow_len = 12'(alw);
    cyc(1, 0, 0);
    chk("R1 active after start", int'(active), 1);
    done_seen = 0; stop = 0;
    for (int p = 0; p < m && !stop; p++) begin
      snt = (sz[p] > lim) ? lim + 1 : sz[p];
      for (int k = 0; k < snt; k++) begin
        if (comb && k == snt - 1) cyc(0, 1, 1);
        else cyc(0, 1, 0);
        if (k >= lim) stop = 1;
      end
      if (!(comb && snt > 0)) cyc(0, 0, !stop); // separate marker
      // R9: excess byte with marker must not count as a closed packet
    end
    cyc(0, 1, 1); // trailing stimulus after completion: must be ignored (R7, R3)
    chk("R8/R3 total", int'(total), exp_tot);
    chk("R5/R8 babble", int'(babble), int'(exp_bab));
    chk("R6/R7 active clear", int'(active), 0);
    chk("R6/R7 single done", done_seen, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int sz[3];
    repeat (2) @(negedge clk);
    chk("reset total", int'(total), 0);
    chk("reset active", int'(active), 0);
    chk("reset babble", int'(babble), 0);
    chk("reset done", int'(done), 0);
    rst_n = 1; @(negedge clk);

    // R2: count 0 ignored
    txn_count = 0; max_pkt = 4; allow_len = 4;
    cyc(1, 0, 0);
    chk("R2 zero count ignored", int'(active), 0);
    // R3: bytes while idle ignored
    cyc(0, 1, 0);
    chk("R3 idle byte ignored", int'(total), 0);

    // sweep over count, packet size, allowed length (R4), packet patterns
    for (int m = 1; m <= 3; m++)
      for (int mps = 1; mps <= 4; mps++)
        for (int alw = 0; alw <= 5; alw++)
          for (int pat = 0; pat < 3; pat++) begin
            int lim;
            lim = (mps < alw) ? mps : alw;
            for (int p = 0; p < 3; p++) sz[p] = (pat + p * (m + 1)) % (lim + 2);
            frame(m, mps, alw, sz, bit'((pat + m) & 1));
          end

    // R2: start while active ignored, R4 packet restart, R9 combined byte+marker
    txn_count = 2; max_pkt = 3; allow_len = 100;
    cyc(1, 0, 0);
    cyc(0, 1, 0); cyc(0, 1, 0);
    txn_count = 1; cyc(1, 0, 0);
    chk("R2 start while active keeps total", int'(total), 2);
    chk("R2 start while active keeps active", int'(active), 1);
    cyc(0, 1, 1);
    chk("R9 byte with marker counted", int'(total), 3);
    chk("R9 first marker not final", int'(active), 1);
    cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
    chk("R4 count restarted per packet", int'(babble), 0);
    cyc(0, 1, 1);
    chk("R9 excess with marker gives babble", int'(babble), 1);
    chk("R5 excess byte dropped", int'(total), 6);
    // R1: restart clears babble and total
    txn_count = 1; cyc(1, 0, 0);
    chk("R1 babble cleared", int'(babble), 0);
    chk("R1 total cleared", int'(total), 0);
    cyc(0, 0, 1);
    chk("R8 empty packet finishes", int'(active), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule